// File: doc/BRIEF.md
# Link Master Port-Enable Register Bank

This block is the control register bank of a serial-link master. A host reaches it over a simple 32-bit register bus that carries a byte address and separate read and write strobes. The bank holds one enable bit for each of the downstream link ports, 64 in the default configuration. The bits are grouped into 32-bit words, and the link logic sees all of them on the `port_en` output.

Each enable word can be changed in three ways, each through its own offset. A load offset replaces the whole word. A set offset ORs the written data into the word. A clear offset removes from the word every bit that is 1 in the written data. Because of the set and clear offsets, software can switch single ports on or off without a read-modify-write. The bank also has a read-only identification word and a command word. Writing the command word with either of its two reset bits returns the whole bank to its power-on state.

The bank decodes the word index from the byte address and ignores the two low address bits. An access whose index lies beyond the implemented register count changes nothing, and the bank reports it on a one-cycle error output. Bus words are carried most significant byte first, so bits 31:24 belong to the lowest byte address. This is only a lane convention and needs no swapping logic.

Top module: `lnkm_port_regs`

## Requirements
- R1: After `rst` is held high across a clock edge, `port_en` is all zeros, `rdata` is zero and `addr_err` is low.
- R2: A write to byte offset 0x010 loads enable word 0 (`port_en[31:0]`) with `wdata`, and a write to 0x014 loads word 1 (`port_en[63:32]`). The new value is on `port_en` after the edge that samples `wr_en`.
- R3: A write to offset 0x018 (word 0) or 0x01C (word 1) ORs `wdata` into that word. Bits that are 0 in `wdata` keep their value.
- R4: A write to offset 0x020 (word 0) or 0x024 (word 1) clears every bit of that word that is 1 in `wdata`. All other bits keep their value.
- R5: A read sampled at a clock edge puts its result on `rdata` after that edge, and `rdata` keeps it until the next read. Offsets 0x010 and 0x014 return the enable words. The set, clear and command offsets, and every other in-range offset except the identification word, return zero. Address bits 1:0 are ignored.
- R6: Offset 0x074 always reads 0xE0050101, and writes to it have no effect.
- R7: A write to offset 0x1D0 with bit 31 or bit 30 of `wdata` set leaves the bank unchanged at the next edge. At the edge after that, `port_en` and `rdata` are cleared, and any access made in that second cycle is discarded. A write to 0x1D0 with both bits clear has no effect, and 0x1D0 reads zero.
- R8: An access whose word index (address bits 11:2) is 128 or more, that is byte address 0x200 or above, changes no state. A read of such an index returns zero. `addr_err` is high for exactly the one cycle after the edge that sampled the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 12 | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| addr_err | output | 1 | One-cycle pulse for an out-of-range access |
| port_en | output | 64 | Per-port enable bits |

## Verification
Writes and reads take effect one edge after they are sampled. The bench therefore drives each strobe at a falling edge and reads `port_en`, `rdata` or `addr_err` at the next falling edge, half a period after the edge that captured the access. The reset command has two steps. The bench first confirms that the enable words are unchanged one cycle after the command write, then confirms that they are zero one cycle later. For `addr_err`, the bench checks that it is high in the cycle after an out-of-range access and low in the cycle after that. The sweeps cover every in-range word index, each single bit of both enable words through the set and clear offsets, and a spread of out-of-range indices.

// File: rtl/lnkm_regs_pkg.sv
package lnkm_regs_pkg;

  localparam int unsigned WORD_W = 32;

  // word indices (byte offset >> 2); bank b uses base + b
  localparam int unsigned IDX_EN_LOAD = 4;    // 0x010
  localparam int unsigned IDX_EN_SET  = 6;    // 0x018
  localparam int unsigned IDX_EN_CLR  = 8;    // 0x020
  localparam int unsigned IDX_IDENT   = 29;   // 0x074
  localparam int unsigned IDX_RST_CMD = 116;  // 0x1D0

  localparam int unsigned CMD_BIT_GENERAL = 31;
  localparam int unsigned CMD_BIT_ERROR   = 30;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
  } en_ctl_t;

endpackage

// File: rtl/lnkm_addr_decode.sv
module lnkm_addr_decode
  import lnkm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 128,
  parameter int unsigned BANKS    = 2,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic [IDX_W-1:0]    idx,
  output logic                in_range,
  output en_ctl_t [BANKS-1:0] ctl,
  output logic                is_ident,
  output logic                is_rst_cmd
);

  assign in_range   = (int'(idx) < int'(NUM_REGS));
  assign is_ident   = in_range && (idx == IDX_W'(IDX_IDENT));
  assign is_rst_cmd = in_range && (idx == IDX_W'(IDX_RST_CMD));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign ctl[b].load = in_range && (idx == IDX_W'(IDX_EN_LOAD + b));
    assign ctl[b].set  = in_range && (idx == IDX_W'(IDX_EN_SET + b));
    assign ctl[b].clr  = in_range && (idx == IDX_W'(IDX_EN_CLR + b));
  end

endmodule

// File: rtl/lnkm_en_word.sv
module lnkm_en_word
  import lnkm_regs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         clr_all,
  input  logic         wr,
  input  en_ctl_t      ctl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (clr_all) begin
      q <= '0;
    end else if (wr) begin
      if (ctl.load)     q <= wdata;
      else if (ctl.set) q <= q | wdata;
      else if (ctl.clr) q <= q & ~wdata;
    end
  end

endmodule

// File: rtl/lnkm_rd_sel.sv
module lnkm_rd_sel
  import lnkm_regs_pkg::*;
#(
  parameter int unsigned        IDX_W   = 10,
  parameter int unsigned        BANKS   = 2,
  parameter logic [WORD_W-1:0]  VERSION = 32'hE005_0101
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic                      in_range,
  input  logic                      is_ident,
  input  logic [BANKS*WORD_W-1:0]   words,
  output logic [WORD_W-1:0]         data
);

  always_comb begin
    data = '0;
    if (in_range) begin
      if (is_ident) data = VERSION;
      for (int b = 0; b < BANKS; b++) begin
        if (idx == IDX_W'(IDX_EN_LOAD + b))
          data = words[b*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/lnkm_port_regs.sv
module lnkm_port_regs
  import lnkm_regs_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter int unsigned       NUM_REGS = 128,
  parameter int unsigned       PORTS    = 64,
  parameter logic [31:0]       VERSION  = 32'hE005_0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              addr_err,
  output logic [PORTS-1:0]  port_en
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned BANKS = PORTS / WORD_W;

  logic [IDX_W-1:0]    idx;
  logic                in_range;
  logic                is_ident;
  logic                is_rst_cmd;
  en_ctl_t [BANKS-1:0] ctl;
  logic [WORD_W-1:0]   rd_word;
  logic                soft_req;
  logic                soft_q;
  logic                clr_all;
  logic [1:0]          unused_lsb;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  lnkm_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .BANKS    (BANKS)
  ) u_dec (
    .idx        (idx),
    .in_range   (in_range),
    .ctl        (ctl),
    .is_ident   (is_ident),
    .is_rst_cmd (is_rst_cmd)
  );

  // reset command: request captured now, applied one edge later
  assign soft_req = wr_en && is_rst_cmd &&
                    (wdata[CMD_BIT_GENERAL] || wdata[CMD_BIT_ERROR]);

  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= soft_req;
  end

  assign clr_all = rst || soft_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_word
    lnkm_en_word #(.W(WORD_W)) u_word (
      .clk     (clk),
      .clr_all (clr_all),
      .wr      (wr_en),
      .ctl     (ctl[b]),
      .wdata   (wdata),
      .q       (port_en[b*WORD_W +: WORD_W])
    );
  end

  lnkm_rd_sel #(
    .IDX_W   (IDX_W),
    .BANKS   (BANKS),
    .VERSION (VERSION)
  ) u_rd (
    .idx      (idx),
    .in_range (in_range),
    .is_ident (is_ident),
    .words    (port_en[BANKS*WORD_W-1:0]),
    .data     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (clr_all) begin
      rdata    <= '0;
      addr_err <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_word;
      addr_err <= (rd_en || wr_en) && !in_range;
    end
  end

endmodule

// File: rtl/lnkm_port_regs_chk.sv
module lnkm_port_regs_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 128,
  parameter int unsigned PORTS    = 64,
  parameter logic [31:0] VERSION  = 32'hE005_0101
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              addr_err,
  input logic [PORTS-1:0]  port_en,
  input logic              soft_q
);

  logic [ADDR_W-3:0] cidx;
  logic              oor;
  assign cidx = addr[ADDR_W-1:2];
  assign oor  = (int'(cidx) >= int'(NUM_REGS));

  a_r2_load_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cidx == 4 && !soft_q) |=> port_en[31:0] == $past(wdata));

  a_r3_set_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cidx == 6 && !soft_q) |=> (port_en[31:0] & $past(wdata)) == $past(wdata));

  a_r4_clr_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cidx == 8 && !soft_q) |=> (port_en[31:0] & $past(wdata)) == 32'h0);

  a_r6_ident: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cidx == 29 && !soft_q) |=> rdata == VERSION);

  a_r7_soft_clear: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> (port_en == '0 && rdata == 32'h0));

  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && oor && !soft_q) |=> addr_err);

  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
    !(rd_en || wr_en) |=> !addr_err);

  a_r8_oor_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && oor && !soft_q) |=> $stable(port_en));

  a_r8_oor_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && oor) |=> rdata == 32'h0);

endmodule

bind lnkm_port_regs lnkm_port_regs_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS),
  .PORTS    (PORTS),
  .VERSION  (VERSION)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .addr_err (addr_err),
  .port_en  (port_en),
  .soft_q   (soft_q)
);

// File: tb/lnkm_port_regs_test.sv
module lnkm_port_regs_test;

  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned NUM_REGS = 128;
  localparam int unsigned PORTS    = 64;
  localparam logic [31:0] VER      = 32'hE005_0101;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              addr_err;
  logic [PORTS-1:0]  port_en;

  int total = 0;
  int bad   = 0;
  logic [63:0] exp_en = '0;

  always #4 clk = ~clk;

  lnkm_port_regs #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PORTS(PORTS), .VERSION(VER)
  ) uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .addr_err(addr_err), .port_en(port_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe sampled at the next rising edge; returns at the falling edge after it
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] exp_rd(input int i);
    if (i == 4)  return exp_en[31:0];
    if (i == 5)  return exp_en[63:32];
    if (i == 29) return VER;
    return 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 port_en", port_en, 64'h0);
    chk("R1 rdata", {32'h0, rdata}, 64'h0);
    chk("R1 addr_err", {63'h0, addr_err}, 64'h0);
    rd(12'h074);
    chk("R6 ident after reset", {32'h0, rdata}, {32'h0, VER});

    // R2 direct loads
    wr(12'h010, 32'hA5A5_0F0F); exp_en[31:0]  = 32'hA5A5_0F0F;
    chk("R2 load low", port_en, exp_en);
    wr(12'h014, 32'h1234_5678); exp_en[63:32] = 32'h1234_5678;
    chk("R2 load high", port_en, exp_en);

    // R3 / R4 single-bit sweeps on both words
    wr(12'h010, 32'h0); wr(12'h014, 32'h0); exp_en = '0;
    chk("R2 zero load", port_en, exp_en);
    for (int i = 0; i < 64; i++) begin
      wr((i < 32) ? 12'h018 : 12'h01C, 32'h1 << (i % 32));
      exp_en[i] = 1'b1;
      chk("R3 set bit", port_en, exp_en);
    end
    for (int i = 0; i < 64; i += 3) begin
      wr((i < 32) ? 12'h020 : 12'h024, 32'h1 << (i % 32));
      exp_en[i] = 1'b0;
      chk("R4 clear bit", port_en, exp_en);
    end
    wr(12'h018, 32'h0); chk("R3 set zero no change", port_en, exp_en);
    wr(12'h024, 32'hFFFF_0000); exp_en[63:48] = '0;
    chk("R4 clear multi", port_en, exp_en);

    // R5 / R6 read sweep over every in-range index, with lane offset
    for (int i = 0; i < NUM_REGS; i++) begin
      rd(ADDR_W'(i * 4 + (i % 4)));
      chk("R5 read index", {32'h0, rdata}, {32'h0, exp_rd(i)});
    end
    rd(12'h010); @(negedge clk);
    chk("R5 rdata holds", {32'h0, rdata}, {32'h0, exp_en[31:0]});
    wr(12'h074, 32'h0); rd(12'h074);
    chk("R6 ident write ignored", {32'h0, rdata}, {32'h0, VER});
    chk("R6 no enable change", port_en, exp_en);

    // R8 out-of-range
    for (int i = NUM_REGS; i < 1024; i += 37) begin
      wr(ADDR_W'(i * 4), 32'hFFFF_FFFF);
      chk("R8 write err", {63'h0, addr_err}, 64'h1);
      chk("R8 write ignored", port_en, exp_en);
      @(negedge clk);
      chk("R8 err single cycle", {63'h0, addr_err}, 64'h0);
      rd(ADDR_W'(i * 4));
      chk("R8 read zero", {32'h0, rdata}, 64'h0);
      chk("R8 read err", {63'h0, addr_err}, 64'h1);
    end
    rd(12'h1FC);
    chk("R8 last index no err", {63'h0, addr_err}, 64'h0);

    // R7 reset command
    wr(12'h1D0, 32'h3FFF_FFFF);
    @(negedge clk);
    chk("R7 no reset bits", port_en, exp_en);
    rd(12'h1D0);
    chk("R7 cmd reads zero", {32'h0, rdata}, 64'h0);
    rd(12'h014);
    wr(12'h1D0, 32'h8000_0000);
    chk("R7 delayed one cycle", port_en, exp_en);
    @(negedge clk);
    exp_en = '0;
    chk("R7 general clear", port_en, exp_en);
    chk("R7 rdata cleared", {32'h0, rdata}, 64'h0);
    wr(12'h010, 32'hFFFF_FFFF); exp_en[31:0] = '1;
    chk("R2 after soft reset", port_en, exp_en);
    wr(12'h1D0, 32'h4000_0000);
    chk("R7 error delayed", port_en, exp_en);
    @(negedge clk);
    chk("R7 error clear", port_en, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule